// File: doc/BRIEF.md
# Reconfigurable Coprocessor Instruction Arbiter

This block sits in the issue path between instruction fetch and two execution targets: a general-purpose core and a reconfigurable unit. Each issued word is either an ordinary core instruction, which passes to the core untouched, or one of eight extension instructions. Five of these are handed to the reconfigurable unit as commands: two configure variants, execute, configure-prefetch and execute-prefetch. Each command carries a microcode address. Two move the data of a parameter between core registers and a local file of exchange registers. The last is a barrier that joins all running executes.

Each execute names one exchange register for its result. That register stays reserved until the unit reports completion. When the unit completes, it writes the result into that register and releases the reservation. A count of outstanding executes lets independent executes overlap, gives back-pressure when the count is full, and holds the barrier until the count drains. Moves that touch a reserved register stall until its execute finishes. The unit also has its own read port into the exchange file so it can fetch parameters.

Top module: `rca_arbiter`

## Requirements
- R1: A word whose bits [31:26] differ from 6'h3B is presented unchanged on `core_instr` with `core_valid` high. `iss_ready` follows `core_ready` and `ru_cmd_valid` stays low.
- R2: An extension word (bits [31:26] = 6'h3B) with sub-op bits [25:23] equal to 0 (partial configure), 1 (complete configure), 3 (configure prefetch) or 4 (execute prefetch) raises `ru_cmd_valid` with `ru_cmd_kind` set to the sub-op and `ru_cmd_addr` set to bits [13:0]. `iss_ready` follows `ru_cmd_ready`. These commands are not counted as outstanding.
- R3: An execute (sub-op 2) raises `ru_cmd_valid` with kind 2, address bits [13:0] and result register bits [22:14] on `ru_cmd_xreg`. On acceptance it reserves that register and adds one to the outstanding count.
- R4: Move-to-exchange (sub-op 5) writes `iss_opnd` into the exchange register given by bits [8:0] on the cycle it is accepted.
- R5: Move-from-exchange (sub-op 6) drives `wb_valid` one cycle after acceptance. `wb_reg` carries bits [22:18] and `wb_data` carries the contents of the exchange register given by bits [8:0].
- R6: Either move holds `iss_ready` low while its exchange register is reserved by a running execute.
- R7: A pulse on `ru_done` writes `ru_done_data` into the register given by `ru_done_xreg`, releases its reservation and subtracts one from a nonzero outstanding count.
- R8: The barrier (sub-op 7) holds `iss_ready` low while any execute is outstanding. It is accepted once the count is zero and sends nothing to the core or the unit.
- R9: An execute holds `iss_ready` and `ru_cmd_valid` low while MAX_OUT executes are outstanding.
- R10: `core_valid` and `ru_cmd_valid` are never high together.
- R11: After reset no execute is outstanding, no register is reserved and `wb_valid` is low.
- R12: `ru_xr_rdata` returns, in the same cycle, the exchange register selected by `ru_xr_raddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issued word present |
| iss_instr | input | 32 | Issued instruction word |
| iss_opnd | input | 32 | Core register value for move-to-exchange |
| iss_ready | output | 1 | Issued word accepted this cycle |
| core_valid | output | 1 | Ordinary instruction towards the core |
| core_instr | output | 32 | Forwarded instruction word |
| core_ready | input | 1 | Core accepts the word |
| ru_cmd_valid | output | 1 | Command towards the reconfigurable unit |
| ru_cmd_kind | output | 3 | Command sub-op |
| ru_cmd_addr | output | 14 | Microcode address |
| ru_cmd_xreg | output | 9 | Result exchange register of an execute |
| ru_cmd_ready | input | 1 | Unit accepts the command |
| ru_done | input | 1 | Unit completes one execute |
| ru_done_xreg | input | 9 | Exchange register receiving the result |
| ru_done_data | input | 32 | Result value |
| ru_xr_raddr | input | 9 | Unit parameter read index |
| ru_xr_rdata | output | 32 | Unit parameter read data |
| wb_valid | output | 1 | Move-from-exchange result valid |
| wb_reg | output | 5 | Destination core register |
| wb_data | output | 32 | Value read from the exchange file |

## Verification
The bench targets the hazard on the result register of an execute. A move-from-exchange issued before completion must stall. If it were released early, it would return the stale value written by an earlier move-to-exchange rather than the completion data. The barrier is tested with two overlapping executes that complete one at a time; a design that tests for one completion instead of an empty count would release it early. The bench fills the count to MAX_OUT and checks that one more execute is refused and is not leaked to the unit. Configure commands are issued as well, and the test confirms that they never block the barrier, which would happen if they were counted.

// File: rtl/rca_pkg.sv
package rca_pkg;
    localparam int INSTR_W   = 32;
    localparam int DATA_W    = 32;
    localparam int XR_AW     = 9;
    localparam int UADDR_W   = 14;
    localparam int CREG_W    = 5;
    localparam int OP_W      = 3;
    localparam int MAJOR_W   = 6;
    localparam logic [MAJOR_W-1:0] EXT_MAJOR = 6'h3B;

    localparam int MAJOR_LSB = INSTR_W - MAJOR_W;
    localparam int OP_LSB    = MAJOR_LSB - OP_W;
    localparam int RESXR_LSB = OP_LSB - XR_AW;
    localparam int CREG_LSB  = OP_LSB - CREG_W;

    typedef enum logic [OP_W-1:0] {
        OP_CFG_PART  = 3'd0,
        OP_CFG_FULL  = 3'd1,
        OP_RUN       = 3'd2,
        OP_CFG_PF    = 3'd3,
        OP_RUN_PF    = 3'd4,
        OP_TO_XR     = 3'd5,
        OP_FROM_XR   = 3'd6,
        OP_JOIN      = 3'd7
    } ext_op_e;

    typedef struct packed {
        logic                 is_ext;
        ext_op_e              op;
        logic [UADDR_W-1:0]   uaddr;
        logic [XR_AW-1:0]     res_xr;
        logic [XR_AW-1:0]     mov_xr;
        logic [CREG_W-1:0]    creg;
    } dec_t;

    function automatic dec_t split_word(input logic [INSTR_W-1:0] w);
        dec_t d;
        d.is_ext = (w[INSTR_W-1 -: MAJOR_W] == EXT_MAJOR);
        d.op     = ext_op_e'(w[OP_LSB +: OP_W]);
        d.uaddr  = w[UADDR_W-1:0];
        d.res_xr = w[RESXR_LSB +: XR_AW];
        d.mov_xr = w[XR_AW-1:0];
        d.creg   = w[CREG_LSB +: CREG_W];
        return d;
    endfunction

    function automatic logic is_unit_cmd(input ext_op_e op);
        return (op == OP_CFG_PART) || (op == OP_CFG_FULL) || (op == OP_RUN) ||
               (op == OP_CFG_PF)   || (op == OP_RUN_PF);
    endfunction
endpackage

// File: rtl/rca_decode.sv
module rca_decode
    import rca_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec,
    output logic [XR_AW-1:0]   hazard_xr
);
    always_comb begin
        dec       = split_word(instr);
        hazard_xr = (dec.op == OP_RUN) ? dec.res_xr : dec.mov_xr;
    end
endmodule

// File: rtl/rca_xregs.sv
module rca_xregs #(
    parameter int AW = 9,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mv_we,
    input  logic [AW-1:0] mv_widx,
    input  logic [DW-1:0] mv_wdata,
    input  logic          cmp_we,
    input  logic [AW-1:0] cmp_widx,
    input  logic [DW-1:0] cmp_wdata,
    input  logic [AW-1:0] mv_ridx,
    output logic [DW-1:0] mv_rdata,
    input  logic [AW-1:0] unit_ridx,
    output logic [DW-1:0] unit_rdata,
    input  logic [AW-1:0] probe_idx,
    output logic          probe_busy,
    input  logic          reserve_en,
    input  logic [AW-1:0] reserve_idx
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0]    store [DEPTH];
    logic [DEPTH-1:0] rsv_q;

    always_ff @(posedge clk) begin
        if (mv_we)  store[mv_widx]  <= mv_wdata;
        if (cmp_we) store[cmp_widx] <= cmp_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsv_q <= '0;
        end else begin
            if (cmp_we)     rsv_q[cmp_widx]    <= 1'b0;
            if (reserve_en) rsv_q[reserve_idx] <= 1'b1;
        end
    end

    assign mv_rdata   = store[mv_ridx];
    assign unit_rdata = store[unit_ridx];
    assign probe_busy = rsv_q[probe_idx];
endmodule

// File: rtl/rca_tracker.sv
module rca_tracker #(
    parameter int MAX_OUT = 8,
    localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic             retire,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);
    logic eff_retire;
    assign eff_retire = retire && (count != '0);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (launch && !eff_retire)
            count <= count + CNT_W'(1);
        else if (!launch && eff_retire)
            count <= count - CNT_W'(1);
    end

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(MAX_OUT));
endmodule

// File: rtl/rca_arbiter.sv
module rca_arbiter
    import rca_pkg::*;
#(
    parameter int MAX_OUT = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                iss_valid,
    input  logic [INSTR_W-1:0]  iss_instr,
    input  logic [DATA_W-1:0]   iss_opnd,
    output logic                iss_ready,
    output logic                core_valid,
    output logic [INSTR_W-1:0]  core_instr,
    input  logic                core_ready,
    output logic                ru_cmd_valid,
    output logic [OP_W-1:0]     ru_cmd_kind,
    output logic [UADDR_W-1:0]  ru_cmd_addr,
    output logic [XR_AW-1:0]    ru_cmd_xreg,
    input  logic                ru_cmd_ready,
    input  logic                ru_done,
    input  logic [XR_AW-1:0]    ru_done_xreg,
    input  logic [DATA_W-1:0]   ru_done_data,
    input  logic [XR_AW-1:0]    ru_xr_raddr,
    output logic [DATA_W-1:0]   ru_xr_rdata,
    output logic                wb_valid,
    output logic [CREG_W-1:0]   wb_reg,
    output logic [DATA_W-1:0]   wb_data
);
    localparam int CNT_W = $clog2(MAX_OUT + 1);

    dec_t              dec;
    logic [XR_AW-1:0]  hazard_xr;
    logic              hazard;
    logic              cnt_empty, cnt_full;
    logic [CNT_W-1:0]  out_cnt;
    logic [DATA_W-1:0] mv_rdata;
    logic              unit_go;
    logic              accept;
    logic              run_fire, to_xr_fire, from_xr_fire, join_fire;

    rca_decode u_dec (
        .instr     (iss_instr),
        .dec       (dec),
        .hazard_xr (hazard_xr)
    );

    // Whether the unit side may take the word at all (before its ready)
    always_comb begin
        unit_go = 1'b0;
        if (dec.is_ext && is_unit_cmd(dec.op))
            unit_go = (dec.op == OP_RUN) ? (!cnt_full && !hazard) : 1'b1;
    end

    always_comb begin
        iss_ready = 1'b0;
        if (!dec.is_ext) begin
            iss_ready = core_ready;
        end else begin
            unique case (dec.op)
                OP_TO_XR, OP_FROM_XR: iss_ready = !hazard;
                OP_JOIN:              iss_ready = cnt_empty;
                default:              iss_ready = unit_go && ru_cmd_ready;
            endcase
        end
    end

    assign accept       = iss_valid && iss_ready;
    assign run_fire     = accept && dec.is_ext && (dec.op == OP_RUN);
    assign to_xr_fire   = accept && dec.is_ext && (dec.op == OP_TO_XR);
    assign from_xr_fire = accept && dec.is_ext && (dec.op == OP_FROM_XR);
    assign join_fire    = accept && dec.is_ext && (dec.op == OP_JOIN);

    assign core_valid   = iss_valid && !dec.is_ext;
    assign core_instr   = iss_instr;
    assign ru_cmd_valid = iss_valid && unit_go;
    assign ru_cmd_kind  = dec.op;
    assign ru_cmd_addr  = dec.uaddr;
    assign ru_cmd_xreg  = dec.res_xr;

    rca_xregs #(.AW(XR_AW), .DW(DATA_W)) u_xr (
        .clk         (clk),
        .rst         (rst),
        .mv_we       (to_xr_fire),
        .mv_widx     (dec.mov_xr),
        .mv_wdata    (iss_opnd),
        .cmp_we      (ru_done),
        .cmp_widx    (ru_done_xreg),
        .cmp_wdata   (ru_done_data),
        .mv_ridx     (dec.mov_xr),
        .mv_rdata    (mv_rdata),
        .unit_ridx   (ru_xr_raddr),
        .unit_rdata  (ru_xr_rdata),
        .probe_idx   (hazard_xr),
        .probe_busy  (hazard),
        .reserve_en  (run_fire),
        .reserve_idx (dec.res_xr)
    );

    rca_tracker #(.MAX_OUT(MAX_OUT)) u_trk (
        .clk    (clk),
        .rst    (rst),
        .launch (run_fire),
        .retire (ru_done),
        .count  (out_cnt),
        .empty  (cnt_empty),
        .full   (cnt_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid <= 1'b0;
            wb_reg   <= '0;
            wb_data  <= '0;
        end else begin
            wb_valid <= from_xr_fire;
            if (from_xr_fire) begin
                wb_reg  <= dec.creg;
                wb_data <= mv_rdata;
            end
        end
    end
endmodule

// File: rtl/rca_arbiter_chk.sv
module rca_arbiter_chk #(
    parameter int MAX_OUT = 8,
    localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             core_valid,
    input logic             ru_cmd_valid,
    input logic             run_fire,
    input logic             join_fire,
    input logic             from_xr_fire,
    input logic             ru_done,
    input logic             wb_valid,
    input logic [CNT_W-1:0] out_cnt
);
    // R10
    excl_target_chk: assert property (@(posedge clk) disable iff (rst)
        !(core_valid && ru_cmd_valid));

    // R8
    join_drained_chk: assert property (@(posedge clk) disable iff (rst)
        join_fire |-> (out_cnt == '0));

    // R5
    wb_after_move_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> $past(from_xr_fire));

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        out_cnt <= CNT_W'(MAX_OUT));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run_fire && !ru_done) |=> (out_cnt == $past(out_cnt) + CNT_W'(1)));

    // R7
    cnt_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_fire && ru_done && out_cnt != '0) |=> (out_cnt == $past(out_cnt) - CNT_W'(1)));
endmodule

bind rca_arbiter rca_arbiter_chk #(.MAX_OUT(MAX_OUT)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .core_valid   (core_valid),
    .ru_cmd_valid (ru_cmd_valid),
    .run_fire     (run_fire),
    .join_fire    (join_fire),
    .from_xr_fire (from_xr_fire),
    .ru_done      (ru_done),
    .wb_valid     (wb_valid),
    .out_cnt      (out_cnt)
);

// File: tb/test_rca_arbiter.sv
module test_rca_arbiter;
    localparam int MAXO = 8;

    logic        clk = 0;
    logic        rst = 1;
    logic        iss_valid = 0;
    logic [31:0] iss_instr = '0;
    logic [31:0] iss_opnd = '0;
    logic        iss_ready;
    logic        core_valid;
    logic [31:0] core_instr;
    logic        core_ready = 1;
    logic        ru_cmd_valid;
    logic [2:0]  ru_cmd_kind;
    logic [13:0] ru_cmd_addr;
    logic [8:0]  ru_cmd_xreg;
    logic        ru_cmd_ready = 1;
    logic        ru_done = 0;
    logic [8:0]  ru_done_xreg = '0;
    logic [31:0] ru_done_data = '0;
    logic [8:0]  ru_xr_raddr = '0;
    logic [31:0] ru_xr_rdata;
    logic        wb_valid;
    logic [4:0]  wb_reg;
    logic [31:0] wb_data;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    rca_arbiter #(.MAX_OUT(MAXO)) i_rca_arbiter (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] w_cfg(input logic [2:0] op, input logic [13:0] a);
        return {6'h3B, op, 9'd0, a};
    endfunction
    function automatic logic [31:0] w_run(input logic [8:0] xr, input logic [13:0] a);
        return {6'h3B, 3'd2, xr, a};
    endfunction
    function automatic logic [31:0] w_mov(input logic [2:0] op, input logic [4:0] cr, input logic [8:0] xr);
        return {6'h3B, op, cr, 9'd0, xr};
    endfunction

    task automatic present(input logic [31:0] w, input logic [31:0] opnd);
        @(negedge clk);
        iss_valid = 1; iss_instr = w; iss_opnd = opnd;
        #1;
    endtask
    task automatic commit();
        @(posedge clk);
        @(negedge clk);
        iss_valid = 0;
        #1;
    endtask
    task automatic complete(input logic [8:0] xr, input logic [31:0] d);
        @(negedge clk);
        ru_done = 1; ru_done_xreg = xr; ru_done_data = d;
        @(posedge clk);
        @(negedge clk);
        ru_done = 0;
        #1;
    endtask
    task automatic join_ready(input bit exp, input string req);
        present(w_cfg(3'd7, 14'd0), 0);
        check(iss_ready == exp, req, 32'(iss_ready), 32'(exp));
        if (iss_ready) commit(); else iss_valid = 0;
    endtask

    task automatic t_reset();
        check(wb_valid == 0, "R11 wb_valid", 32'(wb_valid), 0);
        check(core_valid == 0 && ru_cmd_valid == 0, "R11 idle", 32'({core_valid, ru_cmd_valid}), 0);
        join_ready(1, "R11 join after reset");
    endtask

    task automatic t_pass();
        present(32'h1234_5678, 0);
        check(core_valid && core_instr == 32'h1234_5678, "R1 forward", core_instr, 32'h1234_5678);
        check(!ru_cmd_valid, "R10 unit idle", 32'(ru_cmd_valid), 0);
        check(iss_ready, "R1 ready", 32'(iss_ready), 1);
        core_ready = 0; #1;
        check(!iss_ready, "R1 core stall", 32'(iss_ready), 0);
        iss_valid = 0; core_ready = 1;
    endtask

    task automatic t_cfg();
        logic [2:0] ops [4] = '{3'd0, 3'd1, 3'd3, 3'd4};
        for (int i = 0; i < 4; i++) begin
            present(w_cfg(ops[i], 14'h1A0 + 14'(i)), 0);
            check(ru_cmd_valid && !core_valid, "R2 routed", 32'({ru_cmd_valid, core_valid}), 32'h2);
            check(ru_cmd_kind == ops[i], "R2 kind", 32'(ru_cmd_kind), 32'(ops[i]));
            check(ru_cmd_addr == 14'h1A0 + 14'(i), "R2 addr", 32'(ru_cmd_addr), 32'(14'h1A0 + 14'(i)));
            ru_cmd_ready = 0; #1;
            check(!iss_ready, "R2 unit stall", 32'(iss_ready), 0);
            ru_cmd_ready = 1; #1;
            commit();
        end
        join_ready(1, "R2 not counted");
    endtask

    task automatic t_moves();
        present(w_mov(3'd5, 5'd0, 9'd5), 32'hA5A5_0F0F); commit();
        present(w_mov(3'd5, 5'd0, 9'd511), 32'h5150_0511); commit();
        present(w_mov(3'd6, 5'd3, 9'd5), 0);
        check(iss_ready, "R5 ready", 32'(iss_ready), 1);
        commit();
        check(wb_valid && wb_reg == 5'd3, "R5 wb reg", 32'(wb_reg), 3);
        check(wb_data == 32'hA5A5_0F0F, "R4 data", wb_data, 32'hA5A5_0F0F);
        present(w_mov(3'd6, 5'd31, 9'd511), 0); commit();
        check(wb_data == 32'h5150_0511 && wb_reg == 5'd31, "R5 top index", wb_data, 32'h5150_0511);
        @(negedge clk); #1;
        check(!wb_valid, "R5 single pulse", 32'(wb_valid), 0);
        ru_xr_raddr = 9'd511; #1;
        check(ru_xr_rdata == 32'h5150_0511, "R12 unit read", ru_xr_rdata, 32'h5150_0511);
    endtask

    task automatic t_hazard();
        present(w_mov(3'd5, 5'd0, 9'd10), 32'h0000_0BAD); commit();
        present(w_run(9'd10, 14'h155), 0);
        check(ru_cmd_valid && ru_cmd_kind == 3'd2, "R3 kind", 32'(ru_cmd_kind), 2);
        check(ru_cmd_addr == 14'h155 && ru_cmd_xreg == 9'd10, "R3 fields", 32'({ru_cmd_addr, ru_cmd_xreg}), 32'({14'h155, 9'd10}));
        commit();
        present(w_mov(3'd6, 5'd7, 9'd10), 0);
        check(!iss_ready, "R6 from stall", 32'(iss_ready), 0);
        iss_valid = 0;
        present(w_mov(3'd5, 5'd0, 9'd10), 32'h1111_1111);
        check(!iss_ready, "R6 to stall", 32'(iss_ready), 0);
        iss_valid = 0;
        join_ready(0, "R8 join blocked");
        complete(9'd10, 32'h0000_CAFE);
        present(w_mov(3'd6, 5'd7, 9'd10), 0);
        check(iss_ready, "R7 released", 32'(iss_ready), 1);
        commit();
        check(wb_data == 32'h0000_CAFE, "R7 result", wb_data, 32'h0000_CAFE);
        join_ready(1, "R8 drained");
    endtask

    task automatic t_barrier();
        present(w_run(9'd20, 14'd1), 0); commit();
        present(w_run(9'd21, 14'd2), 0); commit();
        join_ready(0, "R8 two out");
        complete(9'd20, 32'd1);
        join_ready(0, "R8 one out");
        complete(9'd21, 32'd2);
        present(w_cfg(3'd7, 14'd0), 0);
        check(iss_ready && !core_valid && !ru_cmd_valid, "R8 join silent",
              32'({iss_ready, core_valid, ru_cmd_valid}), 32'h4);
        commit();
    endtask

    task automatic t_full();
        for (int i = 0; i < MAXO; i++) begin
            present(w_run(9'(30 + i), 14'd3), 0); commit();
        end
        present(w_run(9'd40, 14'd4), 0);
        check(!iss_ready && !ru_cmd_valid, "R9 full", 32'({iss_ready, ru_cmd_valid}), 0);
        iss_valid = 0;
        complete(9'd30, 32'd0);
        present(w_run(9'd40, 14'd4), 0);
        check(iss_ready, "R9 room", 32'(iss_ready), 1);
        commit();
        for (int i = 1; i < MAXO; i++) complete(9'(30 + i), 32'd0);
        join_ready(0, "R9 last out");
        complete(9'd40, 32'd0);
        join_ready(1, "R9 all drained");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        t_reset();
        t_pass();
        t_cfg();
        t_moves();
        t_hazard();
        t_barrier();
        t_full();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule